// File: doc/BRIEF.md
# PWM Feedback Tracking Converter Controller

This controller sequences a capacitor-tracking analog-to-digital conversion. A start strobe closes a sample switch for a programmable number of clocks so that an external capacitor charges to the input. The switch then opens and the controller drives the capacitor through a resistor with a one-bit stream. Time is divided into slots of a fixed number of clocks. At the end of each slot the controller samples an external comparator and holds the drive for the whole next slot: high while the capacitor sits below the input, low while it sits above.

The conversion result is the number of slots in which the drive was high, out of a total slot count chosen at start time as a power of two. A larger total gives a finer result and a longer conversion. The drive levels bound the usable input range: an input outside them leaves the comparator stuck, and the result pins at zero or full scale. The result is latched together with a single-cycle done pulse and holds until the next conversion finishes.

Top module: `pwm_track_conv`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sample_sw_o`, `drive_o` and `done_o` are 0 and `result_o` is 0.
- R2: A `start_i` sampled high while idle raises `sample_sw_o` on the next cycle and keeps it high for exactly `sample_len_i` cycles, with a length of 0 treated as 1; `sample_sw_o` never rises without a start.
- R3: The cycle `sample_sw_o` falls, `drive_o` takes the comparator value sampled on the last sample cycle; `drive_o` is never high while `sample_sw_o` is high.
- R4: Each slot lasts `SLOT_CLKS` cycles with `drive_o` constant; the next slot's drive equals `cmp_below_i` sampled on the final cycle of the current slot (1 means capacitor below input, drive high).
- R5: The 4-bit field `res_sel_i`, captured with the start, selects N = 2^k slots for value k; values below 6 act as 6 and values above 14 act as 14. Tracking lasts exactly N*`SLOT_CLKS` cycles.
- R6: `done_o` pulses high for one cycle, the cycle after the last slot; in that cycle `result_o` equals the number of slots driven high, and `result_o` changes at no other time.
- R7: A comparator stuck high yields a result of N; a comparator stuck low yields 0.
- R8: A `start_i` during a sample or tracking phase is ignored: the running conversion is unchanged and no new one follows.
- R9: A `start_i` in the cycle `done_o` is high starts a new conversion at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start strobe |
| cmp_below_i | input | 1 | Comparator: 1 when the capacitor is below the input |
| sample_len_i | input | 12 | Sample phase length in cycles |
| res_sel_i | input | 4 | Resolution exponent k, N = 2^k slots |
| sample_sw_o | output | 1 | Sample switch closed |
| drive_o | output | 1 | PWM drive bit to the resistor |
| result_o | output | 15 | Count of high slots from the last conversion |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
Two functions meet in one cycle at the end of a conversion: the done pulse with its result latch, and the acceptance of the next start. The bench raises the start strobe exactly in the done cycle and judges that the switch closes on the following cycle while the previous result stays intact; it also raises start during tracking and checks that it changes nothing. Each cycle the outputs are compared with a behavioural model that also drives a simple capacitor model, so exact high-slot counts such as N/2 for a settled input are known in advance.

// File: rtl/pwm_conv_pkg.sv
package pwm_conv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRACK  = 2'd2
  } conv_phase_e;

endpackage

// File: rtl/pwm_conv_ctrl.sv
module pwm_conv_ctrl
  import pwm_conv_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int SEL_W   = 4,
  parameter int RES_MIN = 6,
  parameter int RES_MAX = 14,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic [SMP_W-1:0] smp_len_i,
  input  logic [SEL_W-1:0] res_sel_i,
  input  logic             slot_end_i,
  input  logic             last_slot_i,
  output logic             sw_o,
  output logic             drive_o,
  output logic             track_go_o,
  output logic             tracking_o,
  output logic [IDX_W-1:0] res_idx_o
);

  conv_phase_e      ph_q;
  logic [SMP_W-1:0] smp_cnt_q;
  logic [SEL_W-1:0] sel_clamped;
  logic [IDX_W-1:0] res_idx_n;

  // range limit on the requested exponent
  always_comb begin
    if (res_sel_i < SEL_W'(RES_MIN))
      sel_clamped = SEL_W'(RES_MIN);
    else if (res_sel_i > SEL_W'(RES_MAX))
      sel_clamped = SEL_W'(RES_MAX);
    else
      sel_clamped = res_sel_i;
    res_idx_n = IDX_W'(sel_clamped - SEL_W'(RES_MIN));
  end

  assign track_go_o = (ph_q == PH_SAMPLE) && (smp_cnt_q == '0);
  assign tracking_o = (ph_q == PH_TRACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      smp_cnt_q <= '0;
      sw_o      <= 1'b0;
      drive_o   <= 1'b0;
      res_idx_o <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q      <= PH_SAMPLE;
            sw_o      <= 1'b1;
            smp_cnt_q <= (smp_len_i == '0) ? '0 : smp_len_i - 1'b1;
            res_idx_o <= res_idx_n;
          end
        end
        PH_SAMPLE: begin
          if (smp_cnt_q == '0) begin
            ph_q    <= PH_TRACK;
            sw_o    <= 1'b0;
            drive_o <= cmp_i;
          end else begin
            smp_cnt_q <= smp_cnt_q - 1'b1;
          end
        end
        PH_TRACK: begin
          if (slot_end_i) begin
            if (last_slot_i) begin
              ph_q    <= PH_IDLE;
              drive_o <= 1'b0;
            end else begin
              drive_o <= cmp_i;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwm_conv_slot_timer.sv
module pwm_conv_slot_timer #(
  parameter int SLOT_CLKS = 4,
  parameter int RES_MIN   = 6,
  parameter int RES_MAX   = 14,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             track_go_i,
  input  logic             tracking_i,
  input  logic [IDX_W-1:0] res_idx_i,
  output logic             slot_end_o,
  output logic             last_slot_o
);

  localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int N_RES  = RES_MAX - RES_MIN + 1;

  logic [SLOT_W-1:0]  slot_cnt_q;
  logic [RES_MAX-1:0] slot_idx_q;
  logic [N_RES-1:0]   term_hit;

  // one terminal-index comparator per selectable resolution
  for (genvar g = 0; g < N_RES; g++) begin : g_term
    localparam logic [RES_MAX-1:0] TERM_IDX = {RES_MAX{1'b1}} >> (RES_MAX - RES_MIN - g);
    assign term_hit[g] = (slot_idx_q == TERM_IDX);
  end

  assign slot_end_o  = tracking_i && (slot_cnt_q == '0);
  assign last_slot_o = term_hit[res_idx_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt_q <= '0;
      slot_idx_q <= '0;
    end else if (track_go_i) begin
      slot_cnt_q <= SLOT_W'(SLOT_CLKS - 1);
      slot_idx_q <= '0;
    end else if (tracking_i) begin
      if (slot_cnt_q == '0) begin
        slot_cnt_q <= SLOT_W'(SLOT_CLKS - 1);
        slot_idx_q <= slot_idx_q + 1'b1;
      end else begin
        slot_cnt_q <= slot_cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_conv_tally.sv
module pwm_conv_tally #(
  parameter int RES_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             slot_end_i,
  input  logic             last_slot_i,
  input  logic             drive_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  logic [RES_W-1:0] hi_q;
  logic [RES_W-1:0] hi_next;

  assign hi_next = hi_q + RES_W'(drive_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clear_i) begin
        hi_q <= '0;
      end else if (slot_end_i) begin
        if (last_slot_i) begin
          result_o <= hi_next;
          done_o   <= 1'b1;
        end else begin
          hi_q <= hi_next;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_track_conv.sv
module pwm_track_conv #(
  parameter int SLOT_CLKS = 4,
  parameter int SMP_W     = 12,
  parameter int SEL_W     = 4,
  parameter int RES_MIN   = 6,
  parameter int RES_MAX   = 14,
  parameter int RES_W     = RES_MAX + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_below_i,
  input  logic [SMP_W-1:0] sample_len_i,
  input  logic [SEL_W-1:0] res_sel_i,
  output logic             sample_sw_o,
  output logic             drive_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  localparam int IDX_W = $clog2(RES_MAX - RES_MIN + 1);

  logic             track_go;
  logic             tracking;
  logic             slot_end;
  logic             last_slot;
  logic [IDX_W-1:0] res_idx;

  pwm_conv_ctrl #(
    .SMP_W  (SMP_W),
    .SEL_W  (SEL_W),
    .RES_MIN(RES_MIN),
    .RES_MAX(RES_MAX),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cmp_i      (cmp_below_i),
    .smp_len_i  (sample_len_i),
    .res_sel_i  (res_sel_i),
    .slot_end_i (slot_end),
    .last_slot_i(last_slot),
    .sw_o       (sample_sw_o),
    .drive_o    (drive_o),
    .track_go_o (track_go),
    .tracking_o (tracking),
    .res_idx_o  (res_idx)
  );

  pwm_conv_slot_timer #(
    .SLOT_CLKS(SLOT_CLKS),
    .RES_MIN  (RES_MIN),
    .RES_MAX  (RES_MAX),
    .IDX_W    (IDX_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .track_go_i (track_go),
    .tracking_i (tracking),
    .res_idx_i  (res_idx),
    .slot_end_o (slot_end),
    .last_slot_o(last_slot)
  );

  pwm_conv_tally #(
    .RES_W(RES_W)
  ) u_tally (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (track_go),
    .slot_end_i (slot_end),
    .last_slot_i(last_slot),
    .drive_i    (drive_o),
    .result_o   (result_o),
    .done_o     (done_o)
  );

endmodule

// File: rtl/pwm_track_conv_chk.sv
module pwm_track_conv_chk #(
  parameter int SLOT_CLKS = 4,
  parameter int RES_MAX   = 14,
  parameter int RES_W     = RES_MAX + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             sample_sw_o,
  input logic             drive_o,
  input logic [RES_W-1:0] result_o,
  input logic             done_o
);

  localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic              prev_sw_q;
  logic              prev_drv_q;
  logic              trk_q;
  logic [SLOT_W-1:0] pos_q;
  logic              first_trk;
  logic [SLOT_W-1:0] pos;

  assign first_trk = !sample_sw_o && prev_sw_q;
  assign pos       = first_trk ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sw_q  <= 1'b0;
      prev_drv_q <= 1'b0;
      trk_q      <= 1'b0;
      pos_q      <= '0;
    end else begin
      prev_sw_q  <= sample_sw_o;
      prev_drv_q <= drive_o;
      if (done_o)         trk_q <= 1'b0;
      else if (first_trk) trk_q <= 1'b1;
      pos_q <= (pos == SLOT_W'(SLOT_CLKS - 1)) ? '0 : pos + 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sample_sw_o && !drive_o && !done_o && result_o == '0));

  a_r2_switch_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_sw_o) |-> $past(start_i));

  a_r3_no_drive_while_sampling: assert property (@(posedge clk) disable iff (rst)
    sample_sw_o |-> !drive_o);

  a_r4_drive_held_in_slot: assert property (@(posedge clk) disable iff (rst)
    ((first_trk || trk_q) && pos != '0) |-> (drive_o == prev_drv_q));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  a_r7_result_bounded: assert property (@(posedge clk) disable iff (rst)
    result_o <= (RES_W'(1) << RES_MAX));

  a_r8_no_sample_in_track: assert property (@(posedge clk) disable iff (rst)
    trk_q |-> !sample_sw_o);

endmodule

bind pwm_track_conv pwm_track_conv_chk #(
  .SLOT_CLKS(SLOT_CLKS),
  .RES_MAX  (RES_MAX),
  .RES_W    (RES_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .sample_sw_o(sample_sw_o),
  .drive_o    (drive_o),
  .result_o   (result_o),
  .done_o     (done_o)
);

// File: tb/pwm_track_conv_bench.sv
`timescale 1ns/1ps
module pwm_track_conv_bench;

  localparam int SLOT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        cmp_below_i;
  logic [11:0] sample_len_i = 12'd1;
  logic [3:0]  res_sel_i = 4'd6;
  logic        sample_sw_o;
  logic        drive_o;
  logic [14:0] result_o;
  logic        done_o;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  int cmp_mode = 0;  // 0 capacitor model, 1 stuck high, 2 stuck low, 3 pattern
  int vin = 1000;
  int vcap = 0;

  // reference model state
  int m_ph = 0, m_cnt = 0, m_slotclk = 0, m_slots = 0, m_hi = 0, m_n = 64, m_result = 0;
  bit m_sw = 0, m_drive = 0, m_done = 0;

  always #2.5 clk = ~clk;

  pwm_track_conv u_pwm_track_conv (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cmp_below_i (cmp_below_i),
    .sample_len_i(sample_len_i),
    .res_sel_i   (res_sel_i),
    .sample_sw_o (sample_sw_o),
    .drive_o     (drive_o),
    .result_o    (result_o),
    .done_o      (done_o)
  );

  always_comb begin
    case (cmp_mode)
      1:       cmp_below_i = 1'b1;
      2:       cmp_below_i = 1'b0;
      3:       cmp_below_i = cyc[3] ^ cyc[5] ^ cyc[8];
      default: cmp_below_i = (vcap < vin);
    endcase
  end

  function automatic int exp_log2(input int sel);
    if (sel < 6) return 6;
    if (sel > 14) return 14;
    return sel;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wrap_up();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  // capacitor: follows the input while sampling, ramps with the drive otherwise
  always @(negedge clk) begin
    if (sample_sw_o) vcap <= vin;
    else             vcap <= vcap + (drive_o ? 1 : -1);
  end

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_sw = 0; m_drive = 0; m_done = 0; m_result = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (start_i) begin
             m_ph = 1; m_sw = 1;
             m_cnt = (sample_len_i == 0) ? 1 : int'(sample_len_i);
             m_n = 1 << exp_log2(int'(res_sel_i));
           end
        1: begin
             m_cnt--;
             if (m_cnt == 0) begin
               m_ph = 2; m_sw = 0; m_drive = cmp_below_i;
               m_slotclk = SLOT; m_slots = 0; m_hi = 0;
             end
           end
        default: begin
             m_slotclk--;
             if (m_slotclk == 0) begin
               m_hi += int'(m_drive);
               m_slots++;
               if (m_slots == m_n) begin
                 m_result = m_hi; m_done = 1; m_ph = 0; m_drive = 0;
               end else begin
                 m_drive = cmp_below_i; m_slotclk = SLOT;
               end
             end
           end
      endcase
    end
    if (cyc > 180000) begin
      misses++;
      $display("FAIL watchdog: actual %0d expected below 180000 cycles", cyc);
      wrap_up();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 sample switch", int'(sample_sw_o), int'(m_sw));
      chk("R4 drive", int'(drive_o), int'(m_drive));
      chk("R6 done", int'(done_o), int'(m_done));
      chk("R6 result", int'(result_o), m_result);
    end
  end

  task automatic run_conv(input int k, input int s, input int mode, input int exp_res,
                          input bit inject, input bit immediate, input string tag);
    int swc;
    int trk;
    cmp_mode = mode; res_sel_i = 4'(k); sample_len_i = 12'(s);
    if (!immediate) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    swc = 0;
    while (sample_sw_o) begin swc++; @(negedge clk); end
    chk({tag, " R2 sample length"}, swc, (s == 0) ? 1 : s);
    trk = 0;
    while (!done_o) begin
      trk++;
      start_i = inject && (trk == 10 || trk == 3);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk({tag, " R5 tracking length"}, trk, (1 << exp_log2(k)) * SLOT);
    chk({tag, " R6 result at done"}, int'(result_o), (exp_res < 0) ? m_result : exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset switch", int'(sample_sw_o), 0);
    chk("R1 reset drive", int'(drive_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    chk("R1 reset result", int'(result_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset result", int'(result_o), 0);

    // settled input: drive alternates, exactly half the slots high
    run_conv(6, 3, 0, 32, 1'b0, 1'b0, "R4 settled k6");
    // below range field clamps to 64 slots; stuck comparator saturates high
    run_conv(0, 0, 1, 64, 1'b0, 1'b0, "R7 high k0");
    // stuck low with stray starts during tracking
    run_conv(7, 5, 2, 0, 1'b1, 1'b0, "R8 low k7");
    repeat (20) @(negedge clk);
    chk("R8 no extra conversion", int'(sample_sw_o), 0);
    chk("R8 result kept", int'(result_o), 0);
    // irregular comparator, value from model
    run_conv(5, 2, 3, -1, 1'b0, 1'b0, "R3 pattern k5");
    // start in the done cycle begins the next conversion at once
    run_conv(8, 4, 3, -1, 1'b0, 1'b1, "R9 back to back");
    run_conv(6, 1, 0, 32, 1'b0, 1'b0, "R3 settled k6");
    // largest resolution, stuck high: full scale
    run_conv(14, 2, 1, 16384, 1'b0, 1'b0, "R7 high k14");
    repeat (5) @(negedge clk);
    wrap_up();
  end

endmodule